// File: doc/BRIEF.md
# Daisy-Chain Position Address Allocator

Each device in a chain of identical drivers works out its own position, 0 to 255, with no strapping pins. All devices share one address clock. A ripple line runs from each device's chain output to the next device's chain input. The device whose chain input is held high becomes the master. It takes position 0 and is the only one that drives the shared clock: the multiplex clock divided by four, for exactly 256 periods per allocation run.

Every device holds its chain output low at the start of a run. A device at position N releases that output N + 1.5 address-clock periods later. Each non-master device counts address-clock rising edges until its chain input rises, and from that count it derives its own position. The successor sees that release one period after the device itself saw its own input rise, so the positions ripple down the chain.

A run starts after reset and on every configuration-write strobe. Between runs the chain output doubles as an active-low interrupt: an automatic plane change produces a fixed-length low pulse. On the last device of the chain, that output serves as an interrupt line.

Top module: `chain_addr_alloc`

## Requirements
- R1: While rst_n is sampled low, the block clears its state: busy=0, chain_out=1, aclk_oe=0, aclk_out=0, addr=0 and no_link=0.
- R2: A run starts by itself after reset, so busy is high from the second rising clock edge after rst_n is released.
- R3: If chain_in is high in the cycle after a run starts, the device is master and takes address 0. For the whole run it holds aclk_oe high. It drives aclk_out with a period of 4 clock cycles, low for the first half, for exactly 256 rising edges. After that, busy and aclk_oe drop.
- R4: During a run, chain_out is low from the start. It goes high while the address clock is high after the clock's (N+2)-th rising edge of the run, where N is the device's address: N + 1.5 periods. If no link is found, chain_out stays low for the whole run.
- R5: A non-master latches an address one less than the number of address-clock rising edges (taken from aclk_in) seen up to the cycle in which chain_in is first sampled high.
- R6: If chain_in never rises during a non-master run, the device latches address 255 and sets no_link. A later run that finds its link clears no_link.
- R7: A cfg_wr pulse restarts a run, even one in progress. In the next cycle busy is high and chain_out and aclk_out are low, and the new run counts its own 256 edges.
- R8: When the block is idle with auto_en high, a one-cycle plane_chg pulse drives chain_out low for exactly 512 clock cycles, starting in the next cycle.
- R9: plane_chg has no effect on chain_out while auto_en is low, and no effect while a run is in progress, either during the run or after it ends.
- R10: A non-master device never raises aclk_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplex clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration-write strobe, starts a run |
| plane_chg | input | 1 | One-cycle automatic plane change event |
| auto_en | input | 1 | Automatic plane switching enabled |
| chain_in | input | 1 | Ripple input from the preceding device (held high on the first) |
| aclk_in | input | 1 | Shared address clock as seen on the bus, synchronous to clk |
| aclk_out | output | 1 | Address clock driven by the master |
| aclk_oe | output | 1 | Output enable for aclk_out onto the shared bus |
| chain_out | output | 1 | Ripple output to the next device, and active-low interrupt |
| busy | output | 1 | High for the whole allocation run |
| addr | output | 8 | Latched chain position |
| no_link | output | 1 | Set when the last run never saw chain_in rise |

## Verification
The hardest case to reach is a non-master device at a chosen position. That needs a second device's clock and a ripple edge that arrive at a known edge count. The bench takes the role of the predecessor and the master: it produces the divided address clock on aclk_in, cycle by cycle, and raises chain_in while the clock is high just after a chosen rising edge. It does this for an early position, a late position and a link that never comes. It also raises a plane change in the middle of a master run, to show that the request does not survive to the end of the run.

// File: rtl/chain_addr_pkg.sv
// Package: shared run-state type for the chain position allocator.
// Assumes: the importing modules use the type only for their control state.
package chain_addr_pkg;

    // Allocation run phases
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // no run in progress
        ST_DECIDE = 2'd1,   // first cycle of a run, master role sampled
        ST_COUNT  = 2'd2    // counting address-clock edges
    } run_state_t;

endpackage

// File: rtl/chain_addr_phase.sv
// Module: divides the multiplex clock into the address clock for a master.
// Assumes: DIV is a power of two of at least 2; the clock is low for the
// first half of each period and restarts low on every run start.
module chain_addr_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic aclk_gen
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PH_W-1:0] ph_q;

    // Phase counter: cleared on start or when idle, advanced during a run
    always_ff @(posedge clk) begin
        if (!rst_n || start || !run) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign aclk_gen = (ph_q >= PH_W'(DIV / 2));
endmodule

// File: rtl/chain_addr_edges.sv
// Module: finds the rising and falling edges of the selected address clock,
// counts the rising edges of the current run and flags the end of the run.
// Assumes: the clock is synchronous to clk and is held low outside counting.
module chain_addr_edges #(
    parameter int SLOTS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       aclk,
    output logic                       rise,
    output logic [$clog2(SLOTS+1)-1:0] rise_cnt,
    output logic                       done
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic prev_q;
    logic fall;

    // Previous clock level: edge detection reference, cleared on run start
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= aclk;
        end
    end

    assign rise = aclk && !prev_q;
    assign fall = !aclk && prev_q;

    // Rising-edge counter for the run, saturating at SLOTS
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rise_cnt <= '0;
        end else if (rise && (rise_cnt != CNT_W'(SLOTS))) begin
            rise_cnt <= rise_cnt + 1'b1;
        end
    end

    assign done = fall && (rise_cnt == CNT_W'(SLOTS));
endmodule

// File: rtl/chain_addr_irq.sv
// Module: fixed-length interrupt pulse timer on the ripple output.
// Assumes: the trigger is already qualified by the caller; clear wins.
module chain_addr_irq #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic trigger,
    output logic active
);
    localparam int IRQ_W = $clog2(LEN + 1);

    logic [IRQ_W-1:0] left_q;

    // Cycles of low pulse remaining; a new trigger is ignored mid-pulse
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (trigger) begin
            left_q <= IRQ_W'(LEN);
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/chain_addr_alloc.sv
// Module: daisy-chain position allocator (top). Runs after reset and on a
// configuration write. The master (chain input high) drives the divided
// address clock; others count edges until their chain input rises.
// Assumes: aclk_in and chain_in are synchronous to clk; the master's own
// clock is used internally, so its aclk_in is ignored.
module chain_addr_alloc
    import chain_addr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CLK_DIV = 4,
    parameter int IRQ_LEN = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              plane_chg,
    input  logic              auto_en,
    input  logic              chain_in,
    input  logic              aclk_in,
    output logic              aclk_out,
    output logic              aclk_oe,
    output logic              chain_out,
    output logic              busy,
    output logic [ADDR_W-1:0] addr,
    output logic              no_link
);
    localparam int SLOTS = 1 << ADDR_W;
    localparam int CNT_W = $clog2(SLOTS + 1);

    run_state_t        state_q;
    logic              boot_q;
    logic              master_q;
    logic              found_q;
    logic              nolink_q;
    logic [CNT_W-1:0]  work_q;
    logic [ADDR_W-1:0] addr_q;

    logic              start;
    logic              aclk_gen;
    logic              aclk_sel;
    logic              rise;
    logic              done;
    logic [CNT_W-1:0]  rise_cnt;
    logic [CNT_W-1:0]  cnt_now;
    logic [CNT_W:0]    need;
    logic              released;
    logic              irq_active;

    assign start = cfg_wr || boot_q;
    assign busy  = (state_q != ST_IDLE);

    // Boot flag: requests one run in the first cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b1;
        end else begin
            boot_q <= 1'b0;
        end
    end

    chain_addr_phase #(.DIV(CLK_DIV)) i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (busy),
        .aclk_gen (aclk_gen)
    );

    assign aclk_sel = (state_q == ST_COUNT) ? (master_q ? aclk_gen : aclk_in) : 1'b0;

    chain_addr_edges #(.SLOTS(SLOTS)) i_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .aclk     (aclk_sel),
        .rise     (rise),
        .rise_cnt (rise_cnt),
        .done     (done)
    );

    assign cnt_now = rise_cnt + {{(CNT_W-1){1'b0}}, rise};

    // Run control: master decision, link detection and end-of-run latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            master_q <= 1'b0;
            found_q  <= 1'b0;
            work_q   <= '0;
            addr_q   <= '0;
            nolink_q <= 1'b0;
        end else if (start) begin
            state_q  <= ST_DECIDE;
            master_q <= 1'b0;
            found_q  <= 1'b0;
            work_q   <= '0;
        end else begin
            case (state_q)
                ST_DECIDE: begin
                    state_q  <= ST_COUNT;
                    master_q <= chain_in;
                    found_q  <= chain_in;
                end
                ST_COUNT: begin
                    if (done) begin
                        state_q  <= ST_IDLE;
                        addr_q   <= found_q ? work_q[ADDR_W-1:0] : {ADDR_W{1'b1}};
                        nolink_q <= !found_q;
                    end else if (!found_q && chain_in) begin
                        found_q <= 1'b1;
                        work_q  <= (cnt_now == '0) ? '0 : cnt_now - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    chain_addr_irq #(.LEN(IRQ_LEN)) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .trigger (plane_chg && auto_en && !busy),
        .active  (irq_active)
    );

    assign need     = {1'b0, work_q} + (CNT_W+1)'(2);
    assign released = found_q && ({1'b0, rise_cnt} >= need);

    assign chain_out = busy ? released : !irq_active;
    assign aclk_oe   = busy && master_q;
    assign aclk_out  = aclk_oe && aclk_gen;
    assign addr      = addr_q;
    assign no_link   = nolink_q;
endmodule

// File: rtl/chain_addr_alloc_chk.sv
// Module: temporal checks on the allocator ports, bound to the top.
// Assumes: a single clock domain and the synchronous active-low reset.
module chain_addr_alloc_chk #(
    parameter int ADDR_W  = 8,
    parameter int IRQ_LEN = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              auto_en,
    input logic              busy,
    input logic              chain_out,
    input logic              aclk_out,
    input logic              aclk_oe,
    input logic [ADDR_W-1:0] addr,
    input logic              no_link
);
    localparam int SLOTS = 1 << ADDR_W;
    localparam int EC_W  = $clog2(SLOTS + 1) + 1;
    localparam int LC_W  = $clog2(IRQ_LEN + 1) + 1;

    logic            busy_q;
    logic            aclk_q;
    logic [EC_W-1:0] edges_q;
    logic [LC_W-1:0] low_q;

    // Delayed copies for run-start and edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            aclk_q <= 1'b0;
        end else begin
            busy_q <= busy;
            aclk_q <= aclk_out;
        end
    end

    // Rising edges of the driven address clock in the current run
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr || (busy && !busy_q)) begin
            edges_q <= '0;
        end else if (aclk_out && !aclk_q && (edges_q != '1)) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    // Length of the current idle low stretch on the ripple output
    always_ff @(posedge clk) begin
        if (!rst_n || busy || chain_out) begin
            low_q <= '0;
        end else if (low_q != '1) begin
            low_q <= low_q + 1'b1;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && chain_out && !aclk_oe && !aclk_out && (addr == '0) && !no_link));

    a_r3_high_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aclk_out) |=> aclk_out);

    a_r3_edge_limit: assert property (@(posedge clk) disable iff (!rst_n)
        edges_q <= EC_W'(SLOTS));

    a_r3_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(aclk_oe)) |-> (edges_q == EC_W'(SLOTS)));

    a_r6_nolink_addr: assert property (@(posedge clk) disable iff (!rst_n)
        no_link |-> (addr == '1));

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (busy && !chain_out && !aclk_out));

    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && chain_out && $past(!chain_out)) |-> (low_q == LC_W'(IRQ_LEN)));

    a_r9_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !busy && chain_out && !auto_en && !cfg_wr) |=> chain_out);
endmodule

bind chain_addr_alloc chain_addr_alloc_chk #(
    .ADDR_W  (ADDR_W),
    .IRQ_LEN (IRQ_LEN)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .auto_en   (auto_en),
    .busy      (busy),
    .chain_out (chain_out),
    .aclk_out  (aclk_out),
    .aclk_oe   (aclk_oe),
    .addr      (addr),
    .no_link   (no_link)
);

// File: tb/test_chain_addr_alloc.sv
// Directed bench: the bench plays master or predecessor as each test needs.
module test_chain_addr_alloc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       plane_chg = 1'b0;
    logic       auto_en = 1'b0;
    logic       chain_in = 1'b1;
    logic       aclk_in = 1'b0;
    logic       aclk_out;
    logic       aclk_oe;
    logic       chain_out;
    logic       busy;
    logic [7:0] addr;
    logic       no_link;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chain_addr_alloc i_chain_addr_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .plane_chg (plane_chg),
        .auto_en   (auto_en),
        .chain_in  (chain_in),
        .aclk_in   (aclk_in),
        .aclk_out  (aclk_out),
        .aclk_oe   (aclk_oe),
        .chain_out (chain_out),
        .busy      (busy),
        .addr      (addr),
        .no_link   (no_link)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_cfg();
        @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Follows a master run from a negedge with busy high until busy drops
    task automatic watch_master(output int rises, output int first_hi,
                                output int bad_gap, output bit oe_ok);
        int  t = 0;
        int  last_t = -1;
        bit  prev = 1'b0;
        rises = 0; first_hi = -1; bad_gap = 0; oe_ok = 1'b1;
        while (busy && t < 3000) begin
            if (!aclk_oe) oe_ok = 1'b0;
            if (aclk_out && !prev) begin
                rises++;
                if (last_t >= 0 && (t - last_t) != 4) bad_gap++;
                last_t = t;
            end
            if (chain_out && first_hi < 0) first_hi = rises;
            prev = aclk_out;
            @(negedge clk);
            t++;
        end
    endtask

    // Acts as predecessor: drives aclk_in for 256 periods, raises chain_in
    // just after rising edge m (m = 0: never)
    task automatic drive_slave(input int m, output int first_hi,
                               output bit oe_ok, output bit low_all);
        int rises = 0;
        first_hi = -1; oe_ok = 1'b1; low_all = 1'b1;
        chain_in = 1'b0;
        pulse_cfg();
        @(negedge clk);
        for (int p = 0; p < 256; p++) begin
            for (int q = 0; q < 4; q++) begin
                if (aclk_oe) oe_ok = 1'b0;
                if (chain_out) low_all = 1'b0;
                if (chain_out && first_hi < 0) first_hi = rises;
                if (q == 2) begin
                    aclk_in = 1'b1;
                    rises++;
                end else if (q == 0) begin
                    aclk_in = 1'b0;
                end
                if (q == 3 && rises == m) chain_in = 1'b1;
                @(negedge clk);
            end
        end
        aclk_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        chain_in = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(chain_out == 1'b1, "R1", "chain_out in reset", chain_out, 1);
        check(aclk_oe == 1'b0 && aclk_out == 1'b0, "R1", "clock drive in reset", aclk_oe, 0);
        check(addr == 8'd0, "R1", "addr in reset", addr, 0);
        check(no_link == 1'b0, "R1", "no_link in reset", no_link, 0);
    endtask

    task automatic t_master_boot();
        int rises, first_hi, bad_gap;
        bit oe_ok;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R2", "busy after reset release", busy, 1);
        check(chain_out == 1'b0, "R4", "chain_out low at run start", chain_out, 0);
        watch_master(rises, first_hi, bad_gap, oe_ok);
        check(rises == 256, "R3", "master clock rising edges", rises, 256);
        check(bad_gap == 0, "R3", "clock period errors", bad_gap, 0);
        check(oe_ok, "R3", "aclk_oe held through run", oe_ok, 1);
        check(first_hi == 2, "R4", "edge index of master ripple release", first_hi, 2);
        @(negedge clk);
        check(aclk_oe == 1'b0, "R3", "aclk_oe after run", aclk_oe, 0);
        check(addr == 8'd0, "R3", "master address", addr, 0);
    endtask

    task automatic t_slave(input int m);
        int first_hi;
        bit oe_ok, low_all;
        drive_slave(m, first_hi, oe_ok, low_all);
        check(busy == 1'b0, "R5", "busy after slave run", busy, 0);
        check(addr == 8'(m - 1), "R5", "slave address", addr, m - 1);
        check(first_hi == m + 1, "R4", "edge index of slave ripple release", first_hi, m + 1);
        check(oe_ok, "R10", "slave never enables clock", oe_ok, 1);
        check(no_link == 1'b0, "R6", "no_link after linked run", no_link, 0);
    endtask

    task automatic t_nolink();
        int first_hi;
        bit oe_ok, low_all;
        drive_slave(0, first_hi, oe_ok, low_all);
        check(addr == 8'd255, "R6", "address without link", addr, 255);
        check(no_link == 1'b1, "R6", "no_link set", no_link, 1);
        check(low_all, "R4", "chain_out low through unlinked run", low_all, 1);
    endtask

    task automatic t_irq();
        int lows = 0;
        bit stayed = 1'b1;
        chain_in = 1'b1;
        auto_en = 1'b0;
        @(negedge clk);
        plane_chg = 1'b1;
        @(negedge clk);
        plane_chg = 1'b0;
        repeat (20) begin
            if (!chain_out) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed, "R9", "no pulse with auto_en low", stayed, 1);
        auto_en = 1'b1;
        plane_chg = 1'b1;
        @(negedge clk);
        plane_chg = 1'b0;
        while (!chain_out && lows < 2000) begin
            lows++;
            @(negedge clk);
        end
        check(lows == 512, "R8", "interrupt pulse length", lows, 512);
    endtask

    task automatic t_busy_irq();
        bit stayed = 1'b1;
        chain_in = 1'b1;
        auto_en = 1'b1;
        pulse_cfg();
        repeat (50) @(negedge clk);
        plane_chg = 1'b1;
        @(negedge clk);
        plane_chg = 1'b0;
        while (busy) begin
            if (!chain_out) stayed = 1'b0;
            @(negedge clk);
        end
        repeat (20) begin
            if (!chain_out) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed, "R9", "plane change during run ignored", stayed, 1);
        auto_en = 1'b0;
    endtask

    task automatic t_restart();
        int rises, first_hi, bad_gap;
        bit oe_ok;
        chain_in = 1'b1;
        pulse_cfg();
        repeat (100) @(negedge clk);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(busy == 1'b1 && chain_out == 1'b0, "R7", "restart state", chain_out, 0);
        watch_master(rises, first_hi, bad_gap, oe_ok);
        check(rises == 256, "R7", "edges after restart", rises, 256);
    endtask

    initial begin
        t_reset();
        t_master_boot();
        t_slave(5);
        t_slave(200);
        t_nolink();
        t_slave(1);
        t_irq();
        t_busy_irq();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule